// File: doc/BRIEF.md
# Utility-Driven Way Partitioner for a Two-Core Shared Cache

This block chooses how the 16 ways of a shared set-associative cache are split between two cores. Each core has an access stream of set index and tag. The block watches only one set out of every 32. For those sampled sets it keeps a shadow tag stack ordered by recency, and it counts how often each core hits at each stack depth. A hit at depth p means that the core would have hit with any allocation of more than p ways.

An interval timer runs while the block accepts accesses. When it expires, the block stops accepting accesses and steps through every legal split, one candidate per cycle. It keeps the split with the most predicted hits, publishes it on two registered way-count outputs, and halves every hit counter so that older behaviour fades. The cache that enforces the split is not part of this block.

Each access port is a valid/ready stream. An access transfers only in a cycle where both valid and ready are high. Ready is low for the whole repartition window of WAYS+1 cycles. During that window a held access waits, and the sender may also withdraw it. Both ready outputs always carry the same value.

Top module: `ucp_way_partitioner`

## Requirements
- R1: After reset both way-count outputs are WAYS/2 (8 and 8), and both ready outputs are high.
- R2: An accepted access changes the monitor only when the low SAMPLE_LOG2 bits of its set index are all zero. That sampled set is tracked in shadow row set>>SAMPLE_LOG2. Accesses to any other set have no effect on later splits.
- R3: In a shadow row, depth 0 is the most recent line. On a hit at depth p, that core's counter p increments and the line moves to depth 0. On a miss, the tag is inserted at depth 0, the line at depth WAYS-1 is dropped, and no counter changes.
- R4: The chosen core-0 way count a lies in 1..WAYS-1 and core 1 receives WAYS-a. The choice maximises the sum of core 0's counters 0..a-1 and core 1's counters 0..WAYS-1-a. On a tie, the smallest a wins.
- R5: After INTERVAL accepting cycles, ready drops for exactly WAYS+1 cycles: one preparation cycle, WAYS-1 scan cycles and one commit cycle. Both way outputs change only at the end of the commit cycle, and they always sum to WAYS.
- R6: At the end of each commit cycle, every hit counter of both cores is shifted right by one bit.
- R7: Hit counters saturate at 2^CNT_W-1 and never wrap.
- R8: An access presented while ready is low is not accepted and has no effect on the monitor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| c0_valid | input | 1 | Core 0 access present |
| c0_ready | output | 1 | Core 0 access can be taken |
| c0_set | input | SET_W | Core 0 set index |
| c0_tag | input | TAG_W | Core 0 tag |
| c1_valid | input | 1 | Core 1 access present |
| c1_ready | output | 1 | Core 1 access can be taken |
| c1_set | input | SET_W | Core 1 set index |
| c1_tag | input | TAG_W | Core 1 tag |
| c0_ways | output | WAY_W | Ways given to core 0 |
| c1_ways | output | WAY_W | Ways given to core 1 |

## Verification
The split is exercised with five kinds of traffic.

- **No traffic.** All counters are zero, so every candidate scores the same. The result of 1 way for core 0 shows that ties go to the smallest candidate.
- **Cyclic reuse.** Core 0 cycles through 13 tags and core 1 through 2. Core 0's hits land at depth 12 and core 1's at depth 1. The expected result of 13 shows that stack depth is measured correctly.
- **Unsampled sets only.** The earlier counts must decay back to the all-zero split. This separates correct sampling from counting every set, and it confirms the halving.
- **Saturation.** Core 0 hits at depth 1 and core 1 at depth 14, each more often than the counter limit. The result is a tie only if the counters clamp.
- **Random traffic.** Random accesses, including accesses held during stalls, are compared every cycle against a queue-based reference model.

// File: rtl/ucp_pkg.sv
package ucp_pkg;
  typedef enum logic [1:0] {
    SR_IDLE,
    SR_PREP,
    SR_SCAN,
    SR_COMMIT
  } srch_state_t;
endpackage

// File: rtl/ucp_shadow_stack.sv
module ucp_shadow_stack #(
  parameter int WAYS  = 16,
  parameter int TAG_W = 10,
  parameter int ROWS  = 8,
  localparam int ROW_W = $clog2(ROWS),
  localparam int POS_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [ROW_W-1:0] row,
  input  logic [TAG_W-1:0] tag,
  output logic             hit,
  output logic [POS_W-1:0] hit_pos
);
  logic [TAG_W-1:0] tags [ROWS][WAYS];
  logic [WAYS-1:0]  vld  [ROWS];
  logic [WAYS-1:0]  match;

  // one comparator per recency depth of the addressed row
  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match[g] = vld[row][g] && (tags[row][g] == tag);
  end

  always_comb begin
    hit     = |match;
    hit_pos = '0;
    for (int j = WAYS - 1; j >= 0; j--) begin
      if (match[j]) hit_pos = POS_W'(j);
    end
  end

  // recency shift: depths at or above the hit (all depths on a miss) move down by one
  always_ff @(posedge clk) begin
    if (upd) begin
      tags[row][0] <= tag;
      for (int j = 1; j < WAYS; j++) begin
        if (!hit || j <= int'(hit_pos)) tags[row][j] <= tags[row][j-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) vld[r] <= '0;
    end else if (upd) begin
      vld[row][0] <= 1'b1;
      for (int j = 1; j < WAYS; j++) begin
        if (!hit || j <= int'(hit_pos)) vld[row][j] <= vld[row][j-1];
      end
    end
  end
endmodule

// File: rtl/ucp_hit_counters.sv
module ucp_hit_counters #(
  parameter int WAYS  = 16,
  parameter int CNT_W = 16,
  localparam int POS_W = $clog2(WAYS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       inc,
  input  logic [POS_W-1:0]           inc_pos,
  input  logic                       halve,
  output logic [WAYS-1:0][CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar g = 0; g < WAYS; g++) begin : g_ctr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt[g] <= '0;
      end else if (halve) begin
        cnt[g] <= cnt[g] >> 1;
      end else if (inc && inc_pos == POS_W'(g) && cnt[g] != CNT_MAX) begin
        cnt[g] <= cnt[g] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ucp_monitor.sv
module ucp_monitor #(
  parameter int WAYS        = 16,
  parameter int SET_W       = 8,
  parameter int TAG_W       = 10,
  parameter int SAMPLE_LOG2 = 5,
  parameter int CNT_W       = 16,
  localparam int ROWS  = 1 << (SET_W - SAMPLE_LOG2),
  localparam int ROW_W = $clog2(ROWS),
  localparam int POS_W = $clog2(WAYS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fire,
  input  logic [SET_W-1:0]           set_idx,
  input  logic [TAG_W-1:0]           tag,
  input  logic                       halve,
  output logic [WAYS-1:0][CNT_W-1:0] cnt
);
  logic             sampled;
  logic [ROW_W-1:0] row;
  logic             hit;
  logic [POS_W-1:0] hit_pos;

  assign sampled = fire && (set_idx[SAMPLE_LOG2-1:0] == '0);
  assign row     = set_idx[SET_W-1:SAMPLE_LOG2];

  ucp_shadow_stack #(.WAYS(WAYS), .TAG_W(TAG_W), .ROWS(ROWS)) u_stack (
    .clk(clk), .rst_n(rst_n), .upd(sampled), .row(row), .tag(tag),
    .hit(hit), .hit_pos(hit_pos)
  );

  ucp_hit_counters #(.WAYS(WAYS), .CNT_W(CNT_W)) u_ctrs (
    .clk(clk), .rst_n(rst_n), .inc(sampled && hit), .inc_pos(hit_pos),
    .halve(halve), .cnt(cnt)
  );
endmodule

// File: rtl/ucp_split_search.sv
module ucp_split_search
  import ucp_pkg::*;
#(
  parameter int WAYS  = 16,
  parameter int CNT_W = 16,
  parameter int WAY_W = 5,
  localparam int POS_W  = $clog2(WAYS),
  localparam int PART_W = CNT_W + POS_W,
  localparam int SUM_W  = PART_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [WAYS-1:0][CNT_W-1:0] h0,
  input  logic [WAYS-1:0][CNT_W-1:0] h1,
  output logic                       busy,
  output logic                       commit,
  output logic [WAY_W-1:0]           best_a
);
  srch_state_t       st;
  logic [WAY_W-1:0]  cand;
  logic [PART_W-1:0] s0, s1, tail1;
  logic [SUM_W-1:0]  best, score;
  logic [POS_W-1:0]  mirror;

  // core 1 prefix for WAYS-1 ways (first candidate gives core 0 one way)
  always_comb begin
    tail1 = '0;
    for (int j = 0; j < WAYS - 1; j++) tail1 = tail1 + PART_W'(h1[j]);
  end

  assign score  = SUM_W'(s0) + SUM_W'(s1);
  assign mirror = POS_W'(WAYS - 1) - cand[POS_W-1:0];
  assign busy   = (st != SR_IDLE);
  assign commit = (st == SR_COMMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SR_IDLE;
      cand   <= '0;
      s0     <= '0;
      s1     <= '0;
      best   <= '0;
      best_a <= WAY_W'(1);
    end else begin
      case (st)
        SR_IDLE: if (start) st <= SR_PREP;
        SR_PREP: begin
          s0   <= PART_W'(h0[0]);
          s1   <= tail1;
          cand <= WAY_W'(1);
          st   <= SR_SCAN;
        end
        SR_SCAN: begin
          if (cand == WAY_W'(1) || score > best) begin
            best   <= score;
            best_a <= cand;
          end
          if (cand == WAY_W'(WAYS - 1)) begin
            st <= SR_COMMIT;
          end else begin
            cand <= cand + 1'b1;
            s0   <= s0 + PART_W'(h0[cand[POS_W-1:0]]);
            s1   <= s1 - PART_W'(h1[mirror]);
          end
        end
        default: st <= SR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ucp_way_partitioner.sv
module ucp_way_partitioner #(
  parameter int WAYS        = 16,
  parameter int SET_W       = 8,
  parameter int TAG_W       = 10,
  parameter int SAMPLE_LOG2 = 5,
  parameter int CNT_W       = 16,
  parameter int INTERVAL    = 5000000,
  localparam int WAY_W = $clog2(WAYS + 1),
  localparam int TMR_W = $clog2(INTERVAL + 1),
  localparam int NCORE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             c0_valid,
  output logic             c0_ready,
  input  logic [SET_W-1:0] c0_set,
  input  logic [TAG_W-1:0] c0_tag,
  input  logic             c1_valid,
  output logic             c1_ready,
  input  logic [SET_W-1:0] c1_set,
  input  logic [TAG_W-1:0] c1_tag,
  output logic [WAY_W-1:0] c0_ways,
  output logic [WAY_W-1:0] c1_ways
);
  logic                                  busy, commit, start, accept;
  logic [WAY_W-1:0]                      best_a;
  logic [TMR_W-1:0]                      tcnt;
  logic [NCORE-1:0]                      fire;
  logic [NCORE-1:0][SET_W-1:0]           set_v;
  logic [NCORE-1:0][TAG_W-1:0]           tag_v;
  logic [NCORE-1:0][WAYS-1:0][CNT_W-1:0] hc;

  assign accept   = !busy;
  assign c0_ready = accept;
  assign c1_ready = accept;
  assign fire     = {c1_valid && accept, c0_valid && accept};
  assign set_v    = {c1_set, c0_set};
  assign tag_v    = {c1_tag, c0_tag};
  assign start    = accept && (tcnt == TMR_W'(INTERVAL - 1));

  for (genvar k = 0; k < NCORE; k++) begin : g_mon
    ucp_monitor #(
      .WAYS(WAYS), .SET_W(SET_W), .TAG_W(TAG_W),
      .SAMPLE_LOG2(SAMPLE_LOG2), .CNT_W(CNT_W)
    ) u_mon (
      .clk(clk), .rst_n(rst_n), .fire(fire[k]), .set_idx(set_v[k]),
      .tag(tag_v[k]), .halve(commit), .cnt(hc[k])
    );
  end

  ucp_split_search #(.WAYS(WAYS), .CNT_W(CNT_W), .WAY_W(WAY_W)) u_search (
    .clk(clk), .rst_n(rst_n), .start(start), .h0(hc[0]), .h1(hc[1]),
    .busy(busy), .commit(commit), .best_a(best_a)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
    end else if (start) begin
      tcnt <= '0;
    end else if (accept) begin
      tcnt <= tcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c0_ways <= WAY_W'(WAYS / 2);
      c1_ways <= WAY_W'(WAYS - WAYS / 2);
    end else if (commit) begin
      c0_ways <= best_a;
      c1_ways <= WAY_W'(WAYS) - best_a;
    end
  end
endmodule

// File: rtl/ucp_way_partitioner_chk.sv
module ucp_way_partitioner_chk #(
  parameter int WAYS        = 16,
  parameter int SET_W       = 8,
  parameter int TAG_W       = 10,
  parameter int SAMPLE_LOG2 = 5,
  parameter int CNT_W       = 16,
  parameter int INTERVAL    = 5000000,
  localparam int WAY_W = $clog2(WAYS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             c0_ready,
  input logic             c1_ready,
  input logic [WAY_W-1:0] c0_ways,
  input logic [WAY_W-1:0] c1_ways
);
  logic [7:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_cnt <= '0;
    else if (c0_ready) low_cnt <= '0;
    else               low_cnt <= low_cnt + 1'b1;
  end

  // R5
  split_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(c0_ways) + int'(c1_ways) == WAYS);

  // R4
  min_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c0_ways >= 1 && c1_ways >= 1);

  // R8
  ready_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c0_ready == c1_ready);

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c0_ways != $past(c0_ways)) |-> !$past(c0_ready));

  // R5
  stall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(c0_ready) |-> (int'(low_cnt) == WAYS + 1));
endmodule

bind ucp_way_partitioner ucp_way_partitioner_chk #(
  .WAYS(WAYS), .SET_W(SET_W), .TAG_W(TAG_W),
  .SAMPLE_LOG2(SAMPLE_LOG2), .CNT_W(CNT_W), .INTERVAL(INTERVAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .c0_ready(c0_ready), .c1_ready(c1_ready),
  .c0_ways(c0_ways), .c1_ways(c1_ways)
);

// File: tb/ucp_way_partitioner_tb.sv
module ucp_way_partitioner_tb;
  localparam int WAYS = 16, SET_W = 8, TAG_W = 6, SLOG = 5, CNT_W = 8, INTERVAL = 300;
  localparam int WAY_W = $clog2(WAYS + 1);
  localparam int ROWS  = 1 << (SET_W - SLOG);
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic clk = 0, rst_n = 0;
  logic c0_valid = 0, c1_valid = 0;
  logic [SET_W-1:0] c0_set = 0, c1_set = 0;
  logic [TAG_W-1:0] c0_tag = 0, c1_tag = 0;
  logic c0_ready, c1_ready;
  logic [WAY_W-1:0] c0_ways, c1_ways;

  ucp_way_partitioner #(.WAYS(WAYS), .SET_W(SET_W), .TAG_W(TAG_W),
    .SAMPLE_LOG2(SLOG), .CNT_W(CNT_W), .INTERVAL(INTERVAL)) u_dut (.*);

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;
  // reference model state
  int hc [2][WAYS];
  int dq [2][ROWS][$];
  int mph = 0, mt = 0, ms = 0, mw0 = WAYS / 2, mcommits = 0;
  int mode = 0, pc [2];
  string lbl = "R1";

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_access(input int k, input int s, input int t);
    int row, pos;
    if ((s % (1 << SLOG)) != 0) return;
    row = s >> SLOG;
    pos = -1;
    foreach (dq[k][row][i]) if (pos < 0 && dq[k][row][i] == t) pos = i;
    if (pos >= 0) begin
      if (hc[k][pos] < MAXC) hc[k][pos]++;
      dq[k][row].delete(pos);
      dq[k][row].push_front(t);
    end else begin
      dq[k][row].push_front(t);
      if (dq[k][row].size() > WAYS) void'(dq[k][row].pop_back());
    end
  endtask

  task automatic model_commit();
    int best, ba;
    best = -1; ba = 1;
    for (int a = 1; a < WAYS; a++) begin
      int s;
      s = 0;
      for (int i = 0; i < a; i++) s += hc[0][i];
      for (int i = 0; i < WAYS - a; i++) s += hc[1][i];
      if (s > best) begin best = s; ba = a; end
    end
    mw0 = ba;
    for (int k = 0; k < 2; k++) for (int i = 0; i < WAYS; i++) hc[k][i] = hc[k][i] / 2;
    mcommits++;
  endtask

  task automatic drive();
    int s [2], t [2];
    bit v [2];
    for (int k = 0; k < 2; k++) begin
      v[k] = 1; s[k] = 0; t[k] = 0;
      case (mode)
        0: v[k] = 0;
        1: begin s[k] = 32 * k; t[k] = (k == 0) ? pc[0] % 13 : pc[1] % 2; end
        2: begin s[k] = (k == 0) ? 1 + pc[0] % 31 : 33; t[k] = (k == 0) ? pc[0] % 3 : 0; end
        3: begin
          v[k] = ($urandom % 3) != 0;
          s[k] = ($urandom % 2 == 0) ? 32 * ($urandom % ROWS) : $urandom % 256;
          t[k] = $urandom % 20;
        end
        default: begin s[k] = 64 + 32 * k; t[k] = (k == 0) ? pc[0] % 2 : pc[1] % 15; end
      endcase
    end
    c0_valid = v[0]; c0_set = SET_W'(s[0]); c0_tag = TAG_W'(t[0]);
    c1_valid = v[1]; c1_set = SET_W'(s[1]); c1_tag = TAG_W'(t[1]);
    // model of the coming clock edge
    if (mph == 0) begin
      for (int k = 0; k < 2; k++) if (v[k]) begin model_access(k, s[k], t[k]); pc[k]++; end
      if (mt == INTERVAL - 1) begin mt = 0; mph = 1; ms = 0; end else mt++;
    end else if (mph == 1) begin
      if (ms == WAYS - 1) mph = 2; else ms++;
    end else begin
      model_commit();
      mph = 0;
    end
  endtask

  task automatic cycle();
    drive();
    @(negedge clk);
    chk({lbl, " ready"}, int'(c0_ready), int'(mph == 0));
    chk({lbl, " R8 ready pair"}, int'(c1_ready), int'(mph == 0));
    chk({lbl, " ways0"}, int'(c0_ways), mw0);
    chk({lbl, " ways1"}, int'(c1_ways), WAYS - mw0);
  endtask

  task automatic run_intervals(input int m, input int n, input string l);
    int target;
    mode = m; lbl = l; pc[0] = 0; pc[1] = 0;
    target = mcommits + n;
    while (mcommits < target && !done) cycle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 reset ways0", int'(c0_ways), 8);
    chk("R1 reset ways1", int'(c1_ways), 8);
    chk("R1 reset ready", int'(c0_ready && c1_ready), 1);
    // R4 all-zero counters tie, smallest candidate wins; R5 timing checked each cycle
    run_intervals(0, 1, "R4 R5 idle");
    chk("R4 tie to smallest", int'(c0_ways), 1);
    // R3 reuse at depth 12 (core 0) and depth 1 (core 1)
    run_intervals(1, 1, "R3 R4 reuse");
    chk("R3 depth split", int'(c0_ways), 13);
    chk("R3 depth split core1", int'(c1_ways), 3);
    // R2 unsampled sets only; R6 halving decays old counts to zero
    run_intervals(2, 9, "R2 R6 unsampled");
    chk("R2 R6 decay to zero split", int'(c0_ways), 1);
    // R7 both cores exceed the counter limit: clamped values tie
    run_intervals(4, 1, "R7 saturation");
    chk("R7 saturated tie", int'(c0_ways), 1);
    // R8 random traffic with requests held during stalls
    run_intervals(3, 6, "R8 R3 random");
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule